// File: doc/BRIEF.md
# Three-Lane Word Serializer with Forwarded Frame Clock

This block turns a 21-bit parallel word into three serial bit streams plus a fourth lane that carries a frame clock. It runs on a bit clock at seven times the parallel word rate. That bit clock is assumed to be already multiplied and phase-locked upstream, and its lock state arrives on an input. The parallel clock enters as a level sampled on the bit clock. Each of its rising edges captures one word. Each data lane then sends a fixed seven-bit slice of that word during the next frame.

A free-running slot counter numbers the seven bit slots of every frame. The frame clock lane is built from this counter, so it keeps toggling even when the parallel clock stops. The serial outputs are modelled as data plus output enables. The enables stay low until the bit-clock lock has been seen after reset. An active-low power-down input also drops every enable, which models the high-impedance state of the pads.

Top module: `ser21_lane_tx`

## Requirements
- R1: A rising edge of `pclk_i`, seen as 0 in one bit-clock cycle and 1 in the next, captures `word_i`. A change of `word_i` while `pclk_i` holds its level has no effect on any later frame.
- R2: In slot j (j = 0..6) of a frame, data lane k (k = 0..2) carries bit 7k+j of the word for that frame. The least significant bit goes first, and all lanes start their word in the same slot.
- R3: `fclk_o` follows the pattern 1,1,0,0,0,1,1 over slots 0 to 6. It falls after slot 1 and rises after slot 4.
- R4: A word captured at a bit-clock edge that does not close slot 6 goes out whole in the very next frame. The captured word is moved into the lanes only at the edge that closes slot 6.
- R5: The slot counter advances on every bit-clock cycle whatever `pclk_i` does. With no new capture, each frame sends the last captured word again.
- R6: While `pwrdn_n_i` is 0, all lane enables and `fclk_oe_o` are 0 from the next bit-clock cycle on. They come back one cycle after `pwrdn_n_i` returns to 1.
- R7: After reset all enables stay 0 until `lock_i` has been 1 for at least one cycle. They are 1 two cycles after that, provided power-down is high. Once lock has been seen, a later drop of `lock_i` does not clear the enables.
- R8: During reset the slot is 0 (`fclk_o` = 1), every enable is 0 and every data lane output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, seven times the word rate |
| rst_n_i | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Bit-clock lock indicator |
| pclk_i | input | 1 | Parallel clock level, sampled on the bit clock |
| word_i | input | 21 | Parallel input word |
| pwrdn_n_i | input | 1 | Active-low power-down |
| lane_d_o | output | 3 | Serial data, one bit per lane |
| lane_oe_o | output | 3 | Output enable per data lane |
| fclk_o | output | 1 | Forwarded frame clock |
| fclk_oe_o | output | 1 | Output enable of the frame clock lane |

## Verification
The assertions assume that `pclk_i`, `word_i`, `lock_i` and `pwrdn_n_i` are synchronous to the bit clock and change only away from its rising edge. They also assume that reset is held across at least one edge before any property is judged. The stimulus changes every input on the falling edge. It raises `pclk_i` only in slot 1, locating that slot from the observed frame clock, so no capture lands on the slot-6 load edge. It holds `pclk_i` both low and high for several frames to exercise the free-running and repeat behaviour.

// File: rtl/ser21_pkg.sv
// Package: shared constants and the frame clock shape for the three-lane serializer.
// Assumes the slot count per frame is at least 2*FCLK_HEAD+1.
package ser21_pkg;

    localparam int unsigned LANES_DEF = 3;
    localparam int unsigned SLOTS_DEF = 7;
    localparam int unsigned FCLK_HEAD = 2;

    // Level of the frame clock in a given slot: high at both ends of a frame.
    function automatic logic frame_level(input int unsigned slot, input int unsigned slots);
        return (slot < FCLK_HEAD) || (slot >= slots - FCLK_HEAD);
    endfunction

endpackage

// File: rtl/ser_slot_timer.sv
// Module: free-running bit-slot counter, 0..SLOTS-1, wrapping every frame.
// Assumes it is clocked by the bit clock; it never stalls.
module ser_slot_timer #(
    parameter int unsigned SLOTS = 7,
    localparam int unsigned SW = $clog2(SLOTS)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    output logic [SW-1:0] slot_o,
    output logic          last_o
);

    assign last_o = (slot_o == SW'(SLOTS - 1));

    // Advance one slot per bit clock, wrapping at the end of the frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            slot_o <= '0;
        end else if (last_o) begin
            slot_o <= '0;
        end else begin
            slot_o <= slot_o + SW'(1);
        end
    end

    p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        last_o |=> (slot_o == '0));
    p_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !last_o |=> (slot_o == $past(slot_o) + SW'(1)));
    p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (int'(slot_o) < SLOTS));

endmodule

// File: rtl/ser_word_capture.sv
// Module: detects a rising edge of the sampled parallel clock and holds the word.
// Assumes pclk_i is synchronous to the bit clock (derived from the same source).
module ser_word_capture #(
    parameter int unsigned WIDTH = 21
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             pclk_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] hold_o
);

    logic pclk_q;
    logic rise;

    assign rise = pclk_i & ~pclk_q;

    // Remember the previous parallel clock level for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            pclk_q <= 1'b0;
        end else begin
            pclk_q <= pclk_i;
        end
    end

    // Take the input word only on a detected rising edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            hold_o <= '0;
        end else if (rise) begin
            hold_o <= word_i;
        end
    end

    p_take_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rise |=> (hold_o == $past(word_i)));
    p_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !rise |=> $stable(hold_o));

endmodule

// File: rtl/ser_lane_shifter.sv
// Module: one serial lane; loads a slice at the frame boundary, shifts LSB first.
// Assumes load_i pulses once per frame, on the edge closing the last slot.
module ser_lane_shifter #(
    parameter int unsigned SLOTS = 7
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [SLOTS-1:0] par_i,
    output logic             bit_o
);

    logic [SLOTS-1:0] sh_q;

    assign bit_o = sh_q[0];

    // Load a fresh slice at the boundary, otherwise move to the next bit.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= par_i;
        end else begin
            sh_q <= sh_q >> 1;
        end
    end

    p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_i |=> (sh_q == $past(par_i)));
    p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_i |=> (sh_q == ($past(sh_q) >> 1)));

endmodule

// File: rtl/ser21_lane_tx.sv
// Module: top of the three-lane serializer with frame clock and power-down.
// Assumes clk_bit_i is already multiplied to LANES' slot rate and locked to
// pclk_i; pads are modelled as data plus output enable.
module ser21_lane_tx
    import ser21_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned SLOTS = SLOTS_DEF,
    localparam int unsigned WIDTH = LANES * SLOTS,
    localparam int unsigned SW = $clog2(SLOTS)
) (
    input  logic             clk_bit_i,
    input  logic             rst_n_i,
    input  logic             lock_i,
    input  logic             pclk_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             pwrdn_n_i,
    output logic [LANES-1:0] lane_d_o,
    output logic [LANES-1:0] lane_oe_o,
    output logic             fclk_o,
    output logic             fclk_oe_o
);

    logic [SW-1:0]    slot;
    logic             slot_last;
    logic [WIDTH-1:0] hold;
    logic             lock_seen_q;
    logic             oe_q;

    ser_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk_i   (clk_bit_i),
        .rst_n_i (rst_n_i),
        .slot_o  (slot),
        .last_o  (slot_last)
    );

    ser_word_capture #(.WIDTH(WIDTH)) u_capture (
        .clk_i   (clk_bit_i),
        .rst_n_i (rst_n_i),
        .pclk_i  (pclk_i),
        .word_i  (word_i),
        .hold_o  (hold)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser_lane_shifter #(.SLOTS(SLOTS)) u_lane (
            .clk_i   (clk_bit_i),
            .rst_n_i (rst_n_i),
            .load_i  (slot_last),
            .par_i   (hold[k*SLOTS +: SLOTS]),
            .bit_o   (lane_d_o[k])
        );
    end

    assign fclk_o = frame_level(int'(slot), SLOTS);

    // Sticky record that the bit clock has reported lock since reset.
    always_ff @(posedge clk_bit_i) begin
        if (!rst_n_i) begin
            lock_seen_q <= 1'b0;
        end else if (lock_i) begin
            lock_seen_q <= 1'b1;
        end
    end

    // Registered output enable: needs lock seen and power-down released.
    always_ff @(posedge clk_bit_i) begin
        if (!rst_n_i) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= lock_seen_q & pwrdn_n_i;
        end
    end

    assign lane_oe_o = {LANES{oe_q}};
    assign fclk_oe_o = oe_q;

    p_pd_quiet_r6: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
        !pwrdn_n_i |=> ((lane_oe_o == '0) && !fclk_oe_o));
    p_lock_gate_r7: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
        !lock_seen_q |=> !fclk_oe_o);
    p_lock_sticky_r7: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
        lock_seen_q |=> lock_seen_q);
    p_fclk_fall_r3: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
        $fell(fclk_o) |-> (slot == SW'(FCLK_HEAD)));
    p_fclk_rise_r3: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
        $rose(fclk_o) |-> (slot == SW'(SLOTS - FCLK_HEAD)));

endmodule

// File: tb/ser21_lane_tx_tb_top.sv
module ser21_lane_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lock;
    logic        pclk;
    logic [20:0] word;
    logic        pwrdn_n;
    logic [2:0]  lane_d;
    logic [2:0]  lane_oe;
    logic        fclk;
    logic        fclk_oe;

    always #10 clk = ~clk;

    ser21_lane_tx dut_i (
        .clk_bit_i (clk),
        .rst_n_i   (rst_n),
        .lock_i    (lock),
        .pclk_i    (pclk),
        .word_i    (word),
        .pwrdn_n_i (pwrdn_n),
        .lane_d_o  (lane_d),
        .lane_oe_o (lane_oe),
        .fclk_o    (fclk),
        .fclk_oe_o (fclk_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int ncyc  = 0;
    bit done  = 0;

    logic [20:0] q_word[$];
    int          q_stamp[$];

    int          bslot    = 0;
    bit          synced   = 0;
    logic        prev_f   = 1'b0;
    logic [20:0] acc      = '0;
    int          fstart   = 0;
    bit          frame_ok = 0;
    logic [20:0] last_exp = '0;
    bit          have_last = 0;
    event        slot1_ev;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: tracks slots from the frame clock, rebuilds frames, compares.
    always @(negedge clk) begin
        ncyc++;
        if (synced) bslot = (bslot + 1) % 7;
        if (!synced && rst_n && prev_f && !fclk) begin
            synced = 1;
            bslot  = 2;
        end
        prev_f = fclk;
        if (synced && rst_n && fclk_oe) begin
            chk("R3 frame clock level", {31'd0, fclk}, {31'd0, (bslot < 2 || bslot >= 5)});
            if (bslot == 0) begin
                acc      = '0;
                fstart   = ncyc;
                frame_ok = 1;
            end
            if (frame_ok) begin
                for (int k = 0; k < 3; k++) acc[7*k + bslot] = lane_d[k];
                if (bslot == 6) begin
                    if (q_word.size() > 0 && q_stamp[0] < fstart) begin
                        last_exp  = q_word.pop_front();
                        void'(q_stamp.pop_front());
                        have_last = 1;
                        chk("R2 R4 lane word", {11'd0, acc}, {11'd0, last_exp});
                    end else if (have_last) begin
                        chk("R5 R1 repeated word", {11'd0, acc}, {11'd0, last_exp});
                    end
                    frame_ok = 0;
                end
            end
        end else begin
            frame_ok = 0;
        end
        if (synced && bslot == 1) -> slot1_ev;
    end

    // Driver: raise pclk in slot 1 with a new word and queue the expectation.
    task automatic send(input logic [20:0] w, input bit keep_high);
        @(slot1_ev);
        pclk = 1'b1;
        word = w;
        q_word.push_back(w);
        q_stamp.push_back(ncyc);
        repeat (3) @(negedge clk);
        if (!keep_high) pclk = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lock = 1'b0; pclk = 1'b0; word = '0; pwrdn_n = 1'b1;
        repeat (5) @(negedge clk);
        // R8: reset state
        chk("R8 lane enables", {29'd0, lane_oe}, 32'd0);
        chk("R8 frame enable", {31'd0, fclk_oe}, 32'd0);
        chk("R8 lane data", {29'd0, lane_d}, 32'd0);
        chk("R8 slot0 frame clock", {31'd0, fclk}, 32'd1);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 no lock keeps enables low", {28'd0, fclk_oe, lane_oe}, 32'd0);
        lock = 1'b1;
        @(negedge clk);
        lock = 1'b0;
        @(negedge clk);
        chk("R7 enables after lock", {28'd0, fclk_oe, lane_oe}, 32'hF);
        repeat (5) @(negedge clk);
        chk("R7 lock sticky", {28'd0, fclk_oe, lane_oe}, 32'hF);
        wait (synced);
        // R2/R4: several patterns
        send(21'h1FFFFF, 0);
        send(21'h000000, 0);
        send(21'h155555, 0);
        send(21'h0AAAAA, 0);
        send(21'h000001, 0);
        send(21'h100000, 0);
        send(21'h07F000, 0);
        send(21'h12D3A5, 0);
        // R5/R1: pclk held low, word changes ignored
        repeat (3) @(negedge clk);
        word = 21'h0F0F0F;
        repeat (21) @(negedge clk);
        word = 21'h1C3C3C;
        repeat (7) @(negedge clk);
        // R5: pclk held high
        send(21'h0BEEF1, 1);
        repeat (3) @(negedge clk);
        word = 21'h055AA5;
        repeat (21) @(negedge clk);
        pclk = 1'b0;
        repeat (7) @(negedge clk);
        // R6: power-down
        pwrdn_n = 1'b0;
        @(negedge clk);
        chk("R6 power-down enables", {28'd0, fclk_oe, lane_oe}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R6 power-down held", {28'd0, fclk_oe, lane_oe}, 32'd0);
        pwrdn_n = 1'b1;
        @(negedge clk);
        chk("R6 power-up enables", {28'd0, fclk_oe, lane_oe}, 32'hF);
        send(21'h13579B, 0);
        send(21'h02468A, 0);
        send(21'h1E0F0F, 0);
        repeat (14) @(negedge clk);
        chk("R4 all words delivered", q_word.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule